// File: doc/BRIEF.md
# Paired Byte Timer Counter

This block holds two 8-bit up-counters that share one register interface. Each counter picks its own count pulse. The pulse comes either from a free-running internal divider (clock divided by 8, 64 or 8192) or from an edge of that channel's external clock pin, which is synchronised inside the block. Each counter can be cleared by one of three single-cycle event inputs: compare match A, compare match B or input capture. A two-bit clear-mode field chooses which one. When a counter wraps from its top value to zero, it raises a sticky overflow flag.

The host reaches each register one byte at a time, or reaches both channels' copies of a register at once as a 16-bit word. A word access writes both bytes in the same clock cycle, and a word read samples both bytes in the same cycle. The two halves of a word therefore always belong to one instant, even while both counters run. A standby input holds both counters at zero. The control and status registers keep their contents during standby.

Top module: `tmr_pair`

## Requirements
- R1: After the synchronous active-high reset, every counter, control and status register reads 0x00, and bus_rdata is 0.
- R2: Byte access (bus_word=0). bus_addr[2:1] selects the register: 00 counter, 01 control, 10 status, 11 unmapped (reads 0, writes ignored). bus_addr[0] selects the channel. Write data comes from bus_wdata[7:0], and a byte read returns the value on bus_rdata[7:0] with bus_rdata[15:8]=0.
- R3: Word access (bus_word=1) ignores bus_addr[0]. Channel 0 occupies bits 15..8 and channel 1 occupies bits 7..0. A word write updates both channels in the same clock edge.
- R4: bus_rdata is registered. It takes the addressed value at the clock edge where bus_rd=1 and holds otherwise, so both halves of a word read come from one cycle.
- R5: Control bits [2:0] select the count source: 001 counts once per 8 cycles, 010 once per 64 cycles and 011 once per 8192 cycles, all taken from one divider that starts at reset. 000 and 111 stop the counter.
- R6: Clock-select values 100, 101 and 110 count rising edges, falling edges, or both edges of the channel's external clock. Each edge gives exactly one increment. The increment lands on the third rising clock edge after the pin changes.
- R7: Control bits [4:3] select the clear source: 00 none, 01 compare match A, 10 compare match B, 11 input capture. A selected event that is high at a clock edge sets the counter to 0x00. Events that are not selected have no effect.
- R8: If a clear and an increment coincide, the counter becomes 0x00, and the overflow flag is not set.
- R9: An increment from 0xFF to 0x00 sets status bit 0, the overflow flag.
- R10: The overflow flag stays set until it is dropped. Writing 0 to status bit 0 drops it only after a status read that saw the flag at 1, and only once for each such read. Writing 1 has no effect. A wrap that happens in the same cycle as the drop keeps the flag set.
- R11: While standby is high, both counters are held at 0x00, even against writes and counting. Control and status registers keep their values.
- R12: A host write to a counter takes priority over a count or a clear event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Holds both counters at zero |
| ext_clk | input | 2 | External count clock, one bit per channel (asynchronous) |
| cmp_a | input | 2 | Compare-match A event, per channel |
| cmp_b | input | 2 | Compare-match B event, per channel |
| capt | input | 2 | Input-capture event, per channel |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = 16-bit access to both channels |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume three things about the inputs. The event inputs and bus strobes are synchronous to clk. At most one of bus_rd and bus_wr is high in a cycle. The external clock pins may change at any time, because only their synchronised copies are checked. The stimulus changes every input at the falling clock edge and never raises both strobes in the same cycle. It toggles the external pins at arbitrary cycle gaps, with gaps of one cycle included. It drives the event inputs as single-cycle pulses or holds them high for several cycles, and a reference model follows the result on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 2;
    localparam int BUS_W  = NUM_CH * CNT_W;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 13;
    localparam int TAP_A  = 3;
    localparam int TAP_B  = 6;
    localparam int TAP_C  = 13;
    localparam int CTL_W  = 5;

    typedef enum logic [2:0] {
        CK_OFF      = 3'd0,
        CK_DIV_A    = 3'd1,
        CK_DIV_B    = 3'd2,
        CK_DIV_C    = 3'd3,
        CK_EXT_RISE = 3'd4,
        CK_EXT_FALL = 3'd5,
        CK_EXT_BOTH = 3'd6,
        CK_OFF_ALT  = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'd0,
        CLR_MATCH_A = 2'd1,
        CLR_MATCH_B = 2'd2,
        CLR_CAPTURE = 2'd3
    } clr_mode_e;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_CTL  = 2'd1,
        REG_STS  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // control byte layout: [4:3] clear mode, [2:0] clock select
    typedef struct packed {
        clr_mode_e clr;
        clk_sel_e  cks;
    } ctl_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } tick_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic match_a;
        logic match_b;
        logic capture;
    } evt_t;

    function automatic logic count_pulse(clk_sel_e s, tick_t t, edge_t e);
        logic r;
        case (s)
            CK_DIV_A:    r = t.a;
            CK_DIV_B:    r = t.b;
            CK_DIV_C:    r = t.c;
            CK_EXT_RISE: r = e.rise;
            CK_EXT_FALL: r = e.fall;
            CK_EXT_BOTH: r = e.rise | e.fall;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic clear_hit(clr_mode_e m, evt_t v);
        logic r;
        case (m)
            CLR_MATCH_A: r = v.match_a;
            CLR_MATCH_B: r = v.match_b;
            CLR_CAPTURE: r = v.capture;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] ctl_to_byte(ctl_t c);
        return {{(CNT_W-CTL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int W  = PRE_W,
    parameter int TA = TAP_A,
    parameter int TB = TAP_B,
    parameter int TC = TAP_C
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t tick
);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    assign tick.a = &div_q[TA-1:0];
    assign tick.b = &div_q[TB-1:0];
    assign tick.c = &div_q[TC-1:0];

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick.a |=> !tick.a);

    // R5
    tick_nested_chk: assert property (@(posedge clk) disable iff (rst)
        (tick.c |-> tick.b) and (tick.b |-> tick.a));

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t edg
);

    // [0] first synchroniser stage, [1] second stage, [2] previous sample
    logic [2:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[1:0], pin};
    end

    assign edg.rise = shift_q[1] & ~shift_q[2];
    assign edg.fall = ~shift_q[1] & shift_q[2];

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        edg.rise |=> !edg.rise);

    // R6
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        edg.fall |=> !edg.fall);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  tick_t            tick,
    input  edge_t            ext_edge,
    input  evt_t             evt,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ctl_we,
    input  ctl_t             ctl_wdata,
    input  logic             sts_rd,
    input  logic             sts_we,
    input  logic             sts_wbit,
    output logic [CNT_W-1:0] cnt_q,
    output ctl_t             ctl_q,
    output logic             ovf_q
);

    logic step;
    logic clr_now;
    logic wrap;
    logic arm_q;
    logic ovf_drop;

    assign step     = count_pulse(ctl_q.cks, tick, ext_edge);
    assign clr_now  = clear_hit(ctl_q.clr, evt);
    assign wrap     = step && !clr_now && !cnt_we && !standby && (cnt_q == '1);
    assign ovf_drop = sts_we && !sts_wbit && arm_q;

    always_ff @(posedge clk) begin
        if (rst || standby) cnt_q <= '0;
        else if (cnt_we)    cnt_q <= cnt_wdata;
        else if (clr_now)   cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           ovf_q <= 1'b0;
        else if (wrap)     ovf_q <= 1'b1;
        else if (ovf_drop) ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                   arm_q <= 1'b0;
        else if (ovf_drop)         arm_q <= 1'b0;
        else if (sts_rd && ovf_q)  arm_q <= 1'b1;
    end

    // R9
    ovf_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(cnt_q) == '1) && (cnt_q == '0));

    // R8
    clear_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_now && !cnt_we) |=> (cnt_q == '0) && !$rose(ovf_q));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(sts_we && !sts_wbit)) |=> ovf_q);

    // R11
    standby_zero_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> (cnt_q == '0));

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !standby) |=> (cnt_q == $past(cnt_wdata)));

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.cks == CK_OFF || ctl_q.cks == CK_OFF_ALT) && !cnt_we && !standby && !clr_now)
        |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic [NUM_CH-1:0] ext_clk,
    input  logic [NUM_CH-1:0] cmp_a,
    input  logic [NUM_CH-1:0] cmp_b,
    input  logic [NUM_CH-1:0] capt,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    tick_t    tick;
    reg_sel_e sel;

    logic [CNT_W-1:0]               cnt_q [NUM_CH];
    ctl_t                           ctl_q [NUM_CH];
    logic [NUM_CH-1:0]              ovf_q;
    logic [NUM_CH-1:0][CNT_W-1:0]   rv;
    logic [BUS_W-1:0]               word_rd;
    logic [BUS_W-1:0]               rd_next;

    assign sel = reg_sel_e'(bus_addr[2:1]);

    tmr_prescaler i_prescaler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        edge_t            ext_edge;
        evt_t             evt;
        logic             hit;
        logic [CNT_W-1:0] lane;

        assign hit  = bus_word || (bus_addr[0] == 1'(i));
        assign lane = bus_word ? bus_wdata[(NUM_CH-1-i)*CNT_W +: CNT_W]
                               : bus_wdata[CNT_W-1:0];
        assign evt  = '{match_a: cmp_a[i], match_b: cmp_b[i], capture: capt[i]};

        tmr_edge_sync i_sync (
            .clk (clk),
            .rst (rst),
            .pin (ext_clk[i]),
            .edg (ext_edge)
        );

        tmr_channel i_chan (
            .clk       (clk),
            .rst       (rst),
            .standby   (standby),
            .tick      (tick),
            .ext_edge  (ext_edge),
            .evt       (evt),
            .cnt_we    (bus_wr && hit && sel == REG_CNT),
            .cnt_wdata (lane),
            .ctl_we    (bus_wr && hit && sel == REG_CTL),
            .ctl_wdata (ctl_t'(lane[CTL_W-1:0])),
            .sts_rd    (bus_rd && hit && sel == REG_STS),
            .sts_we    (bus_wr && hit && sel == REG_STS),
            .sts_wbit  (lane[0]),
            .cnt_q     (cnt_q[i]),
            .ctl_q     (ctl_q[i]),
            .ovf_q     (ovf_q[i])
        );

        always_comb begin
            case (sel)
                REG_CNT: rv[i] = cnt_q[i];
                REG_CTL: rv[i] = ctl_to_byte(ctl_q[i]);
                REG_STS: rv[i] = {{(CNT_W-1){1'b0}}, ovf_q[i]};
                default: rv[i] = '0;
            endcase
        end
    end

    always_comb begin
        word_rd = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            word_rd[(NUM_CH-1-i)*CNT_W +: CNT_W] = rv[i];
        end
    end

    assign rd_next = bus_word ? word_rd : {{(BUS_W-CNT_W){1'b0}}, rv[bus_addr[0]]};

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R3
    word_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word && sel == REG_CNT && !standby)
        |=> (cnt_q[0] == $past(bus_wdata[BUS_W-1 -: CNT_W]))
         && (cnt_q[1] == $past(bus_wdata[CNT_W-1:0])));

endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic [1:0]  ext_clk = '0;
    logic [1:0]  cmp_a = '0;
    logic [1:0]  cmp_b = '0;
    logic [1:0]  capt = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference model state
    int m_cnt[2], m_cks[2], m_clr[2], m_ovf[2], m_arm[2];
    int h1[2], h2[2], h3[2];
    int pc;
    int exp_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .ext_clk   (ext_clk),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .capt      (capt),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    function automatic int byteval(int ch, int sel);
        case (sel)
            0: return m_cnt[ch];
            1: return (m_clr[ch] << 3) | m_cks[ch];
            2: return m_ovf[ch];
            default: return 0;
        endcase
    endfunction

    // cycle-by-cycle behavioural model
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_cks[c] = 0; m_clr[c] = 0; m_ovf[c] = 0; m_arm[c] = 0;
                h1[c] = 0; h2[c] = 0; h3[c] = 0;
            end
            pc = 0;
            exp_rd = 0;
        end else begin
            int sel;
            bit ta, tb, tc;
            sel = int'(bus_addr) >> 1;
            if (bus_rd) begin
                if (bus_word) exp_rd = (byteval(0, sel) << 8) | byteval(1, sel);
                else          exp_rd = byteval(int'(bus_addr[0]), sel);
            end
            ta = (pc % 8) == 7;
            tb = (pc % 64) == 63;
            tc = (pc % 8192) == 8191;
            pc++;
            for (int c = 0; c < 2; c++) begin
                bit rise, fall, inc, clr, hit, cwe, twe, swe, srd, wrap, drop;
                int lane;
                rise = h2[c] == 1 && h3[c] == 0;
                fall = h2[c] == 0 && h3[c] == 1;
                case (m_cks[c])
                    1: inc = ta;
                    2: inc = tb;
                    3: inc = tc;
                    4: inc = rise;
                    5: inc = fall;
                    6: inc = rise | fall;
                    default: inc = 0;
                endcase
                case (m_clr[c])
                    1: clr = cmp_a[c];
                    2: clr = cmp_b[c];
                    3: clr = capt[c];
                    default: clr = 0;
                endcase
                hit  = bus_word || (int'(bus_addr[0]) == c);
                lane = bus_word ? ((c == 0) ? int'(bus_wdata[15:8]) : int'(bus_wdata[7:0]))
                                : int'(bus_wdata[7:0]);
                cwe  = bus_wr && hit && sel == 0;
                twe  = bus_wr && hit && sel == 1;
                swe  = bus_wr && hit && sel == 2;
                srd  = bus_rd && hit && sel == 2;
                wrap = inc && !clr && !cwe && !standby && m_cnt[c] == 255;
                drop = swe && (lane % 2 == 0) && m_arm[c] == 1;
                if (standby)  m_cnt[c] = 0;
                else if (cwe) m_cnt[c] = lane;
                else if (clr) m_cnt[c] = 0;
                else if (inc) m_cnt[c] = (m_cnt[c] + 1) % 256;
                if (twe) begin
                    m_cks[c] = lane % 8;
                    m_clr[c] = (lane >> 3) % 4;
                end
                if (drop)                      m_arm[c] = 0;
                else if (srd && m_ovf[c] == 1) m_arm[c] = 1;
                if (wrap)      m_ovf[c] = 1;
                else if (drop) m_ovf[c] = 0;
                h3[c] = h2[c];
                h2[c] = h1[c];
                h1[c] = int'(ext_clk[c]);
            end
        end
    end

    // compare the registered read data with the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) check(bus_rdata, 16'(exp_rd), {phase, " model"});
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_idle();
        bus_rd = 1'b1; bus_wr = 1'b0; bus_word = 1'b1; bus_addr = 3'd0;
    endtask

    task automatic wr(input logic [2:0] a, input logic w, input logic [15:0] d);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        set_idle();
    endtask

    task automatic rd_check(input logic [2:0] a, input logic w, input logic [15:0] exp,
                            input string tag);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_word = w; bus_addr = a;
        @(negedge clk);
        check(bus_rdata, exp, tag);
        set_idle();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int kind, input int ch);
        case (kind)
            0: cmp_a[ch] = 1'b1;
            1: cmp_b[ch] = 1'b1;
            default: capt[ch] = 1'b1;
        endcase
        @(negedge clk);
        cmp_a = '0; cmp_b = '0; capt = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        set_idle();
        @(negedge clk);

        // R1 reset state of every byte register
        phase = "R1";
        for (int a = 0; a < 6; a++) rd_check(3'(a), 1'b0, 16'h0000, "R1 reset");

        // R2 byte access
        phase = "R2";
        wr(3'd0, 1'b0, 16'hFF5A);
        wr(3'd1, 1'b0, 16'h00C3);
        rd_check(3'd0, 1'b0, 16'h005A, "R2 byte cnt0");
        rd_check(3'd1, 1'b0, 16'h00C3, "R2 byte cnt1");
        wr(3'd6, 1'b0, 16'h00FF);
        rd_check(3'd6, 1'b0, 16'h0000, "R2 unmapped");
        rd_check(3'd0, 1'b1, 16'h5AC3, "R4 word read");

        // R3 word write, channel 0 upper
        phase = "R3";
        wr(3'd0, 1'b1, 16'hA55A);
        rd_check(3'd0, 1'b0, 16'h00A5, "R3 upper byte");
        rd_check(3'd1, 1'b0, 16'h005A, "R3 lower byte");

        // R5 internal divider taps, R4 coherent word reads each cycle
        phase = "R5";
        wr(3'd0, 1'b1, 16'h0000);
        wr(3'd2, 1'b1, 16'h0102);
        idle(300);
        wr(3'd2, 1'b1, 16'h0307);
        idle(16400);
        wr(3'd2, 1'b1, 16'h0000);
        rd_check(3'd2, 1'b1, 16'h0000, "R5 stop codes");

        // R6 external edges
        phase = "R6";
        wr(3'd2, 1'b1, 16'h0405);
        for (int k = 0; k < 40; k++) begin
            ext_clk = ext_clk ^ 2'(1 + (k % 3));
            idle(1 + (k % 5));
        end
        wr(3'd2, 1'b1, 16'h0606);
        for (int k = 0; k < 30; k++) begin
            ext_clk = ext_clk ^ 2'(k % 4);
            idle(1 + (k % 4));
        end
        idle(6);
        wr(3'd2, 1'b0, 16'h0006);
        wr(3'd0, 1'b0, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            ext_clk[0] = ~ext_clk[0];
            idle(4);
        end
        idle(6);
        wr(3'd2, 1'b0, 16'h0000);
        rd_check(3'd0, 1'b0, 16'h0003, "R6 both-edge count");

        // R7 clear source selection
        phase = "R7";
        wr(3'd2, 1'b0, 16'h0008);
        wr(3'd0, 1'b0, 16'h0040);
        pulse(1, 0);
        rd_check(3'd0, 1'b0, 16'h0040, "R7 match B ignored in mode 01");
        pulse(0, 0);
        rd_check(3'd0, 1'b0, 16'h0000, "R7 match A clears");
        wr(3'd2, 1'b0, 16'h0010);
        wr(3'd0, 1'b0, 16'h0041);
        pulse(0, 0);
        rd_check(3'd0, 1'b0, 16'h0041, "R7 match A ignored in mode 10");
        pulse(1, 0);
        rd_check(3'd0, 1'b0, 16'h0000, "R7 match B clears");
        wr(3'd2, 1'b0, 16'h0018);
        wr(3'd0, 1'b0, 16'h0042);
        pulse(2, 0);
        rd_check(3'd0, 1'b0, 16'h0000, "R7 capture clears");
        wr(3'd2, 1'b0, 16'h0000);
        wr(3'd0, 1'b0, 16'h0043);
        pulse(0, 0); pulse(1, 0); pulse(2, 0);
        rd_check(3'd0, 1'b0, 16'h0043, "R7 mode 00 never clears");

        // R9 wrap sets flag, R10 drop protocol
        phase = "R9";
        wr(3'd3, 1'b0, 16'h0001);
        wr(3'd1, 1'b0, 16'h00FC);
        idle(40);
        wr(3'd3, 1'b0, 16'h0000);
        rd_check(3'd5, 1'b0, 16'h0001, "R9 overflow set");
        phase = "R10";
        wr(3'd5, 1'b0, 16'h0001);
        rd_check(3'd5, 1'b0, 16'h0001, "R10 write 1 ignored");
        wr(3'd5, 1'b0, 16'h0000);
        rd_check(3'd5, 1'b0, 16'h0000, "R10 armed drop");
        wr(3'd3, 1'b0, 16'h0001);
        wr(3'd1, 1'b0, 16'h00FF);
        idle(10);
        wr(3'd3, 1'b0, 16'h0000);
        wr(3'd5, 1'b0, 16'h0000);
        rd_check(3'd5, 1'b0, 16'h0001, "R10 drop without read ignored");
        wr(3'd5, 1'b0, 16'h0000);
        rd_check(3'd5, 1'b0, 16'h0000, "R10 drop after read");

        // R8 clear beats increment, no overflow
        phase = "R8";
        bus_rd = 1'b1; bus_word = 1'b0; bus_addr = 3'd4;
        @(negedge clk);
        wr(3'd4, 1'b0, 16'h0000);
        rd_check(3'd4, 1'b0, 16'h0000, "R8 flag cleared first");
        wr(3'd2, 1'b0, 16'h0019);
        capt[0] = 1'b1;
        wr(3'd0, 1'b0, 16'h00FF);
        idle(20);
        capt[0] = 1'b0;
        wr(3'd2, 1'b0, 16'h0000);
        rd_check(3'd0, 1'b0, 16'h0000, "R8 counter held at zero");
        rd_check(3'd4, 1'b0, 16'h0000, "R8 no overflow from clear");

        // R12 write wins over a clear in the same cycle
        phase = "R12";
        wr(3'd2, 1'b0, 16'h0018);
        capt[0] = 1'b1;
        wr(3'd0, 1'b0, 16'h0077);
        capt[0] = 1'b0;
        wr(3'd2, 1'b0, 16'h0000);
        rd_check(3'd0, 1'b0, 16'h0077, "R12 write over capture clear");

        // R11 standby
        phase = "R11";
        wr(3'd2, 1'b0, 16'h0001);
        wr(3'd0, 1'b1, 16'h1122);
        standby = 1'b1;
        wr(3'd1, 1'b0, 16'h0055);
        idle(3);
        rd_check(3'd0, 1'b1, 16'h0000, "R11 counters held");
        rd_check(3'd2, 1'b0, 16'h0001, "R11 control kept");
        standby = 1'b0;
        wr(3'd2, 1'b0, 16'h0000);

        // mixed traffic against the model
        phase = "R7 mix";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom % 64);
            ext_clk = 2'($urandom);
            cmp_a = (r == 1) ? 2'($urandom) : 2'b00;
            cmp_b = (r == 2) ? 2'($urandom) : 2'b00;
            capt  = (r == 3) ? 2'($urandom) : 2'b00;
            standby = (r == 4);
            if (r >= 5 && r < 9) begin
                bus_rd = 1'b0; bus_wr = 1'b1; bus_word = 1'($urandom);
                bus_addr = 3'($urandom % 6); bus_wdata = 16'($urandom);
            end else if (r >= 9 && r < 14) begin
                bus_rd = 1'b1; bus_wr = 1'b0; bus_word = 1'($urandom);
                bus_addr = 3'($urandom % 6);
            end else begin
                set_idle();
            end
            @(negedge clk);
        end
        cmp_a = '0; cmp_b = '0; capt = '0; standby = 1'b0;
        set_idle();
        idle(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule